// File: doc/BRIEF.md
# Configurable Request/Acknowledge Handshake Controller

This block carries one data word from a sending side to a receiving side over two handshake wires, a request driven by the sender and an acknowledge driven by the receiver. Neither side counts cycles of the other: each acts only on what it sees on the opposite wire or on its own hold timer. A selector picks one of three disciplines: unlinked, half-linked and fully linked. The discipline decides whether each side removes its wire after a fixed hold time or after an edge on the other wire. The length of a transfer therefore depends on how long the receiver takes to become ready.

The sender starts a transfer on a start pulse. It latches the word and the discipline, raises request, and pulses a done flag once its part of the transfer is over. The receiver captures the word when request rises. It raises acknowledge as soon as its ready input allows, and removes acknowledge according to the discipline. Both sides run from one clock. The block contains no synchronizers, so it models and exercises the protocol inside one clock domain.

Top module: `hs_link_ctrl`

## Requirements
- R1: While rst_n is low and right after reset, req_o, ack_o and done_o are 0 and rx_data_o is 0.
- R2: start_i is taken only when the sender is idle and both req_o and ack_o are 0 at that clock edge; otherwise it is ignored: no new request, no change to the word or discipline in flight, no extra done pulse.
- R3: mode_sel encoding: 2'b00 unlinked, 2'b01 half-linked, 2'b10 and 2'b11 fully linked. The value is latched when start_i is taken, and later changes of mode_sel do not alter the transfer in flight.
- R4: Unlinked mode: req_o is high for exactly MST_HOLD cycles whatever ack_o does, and done_o pulses in the first cycle req_o is low again.
- R5: In unlinked and half-linked modes, ack_o stays high for exactly SLV_HOLD cycles, whatever req_o does.
- R6: Half-linked mode: req_o stays high until the sender sees ack_o high, then falls one cycle later. done_o pulses in that same cycle.
- R7: Fully linked mode: req_o falls one cycle after ack_o rises. ack_o stays high until the receiver sees req_o low and falls one cycle later. done_o pulses one cycle after ack_o falls.
- R8: The receiver raises ack_o one cycle after it first sees req_o high if slv_ready_i is high then. Otherwise it raises ack_o one cycle after the first edge at which slv_ready_i is high.
- R9: rx_data_o takes the word that was on wdata_i when start_i was taken, one cycle after req_o rises.
- R10: done_o is high for exactly one cycle per taken start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Discipline select (see R3) |
| start_i | input | 1 | Begin a transfer |
| wdata_i | input | DATA_W | Word to send |
| slv_ready_i | input | 1 | Receiver may acknowledge |
| req_o | output | 1 | Request wire |
| ack_o | output | 1 | Acknowledge wire |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rx_data_o | output | DATA_W | Word captured by the receiver |

## Verification
Two kinds of events can land on the same edge: a fall of the acknowledge wire and a new start, or the expiry of both hold timers. In half-linked mode with an immediately ready receiver, the bench raises start in the cycle just before acknowledge falls. That start sees acknowledge still high and must be dropped, and the bench judges this through the request-high count and the single done pulse. In unlinked mode with the default holds, the sender's hold and the receiver's hold end on the same edge. Each side's own timing is then checked at the wires.

// File: rtl/hs_pkg.sv
// Shared types for the handshake controller.
// Assumes: mode codes come from a two-bit selector; code 3 aliases fully linked.
package hs_pkg;

    typedef enum logic [1:0] {
        HS_UNLINKED = 2'd0,
        HS_HALF     = 2'd1,
        HS_FULL     = 2'd2
    } hs_mode_e;

    // Map the raw selector onto a discipline.
    function automatic hs_mode_e hs_decode(input logic [1:0] sel);
        case (sel)
            2'd0:    return HS_UNLINKED;
            2'd1:    return HS_HALF;
            default: return HS_FULL;
        endcase
    endfunction

endpackage

// File: rtl/hs_hold_timer.sv
// Cycle counter for fixed-delay wire removal.
// While run is high it counts cycles; expire is high on the HOLD-th cycle of run.
// Assumes: HOLD >= 1; run drops (or restarts) after expire.
module hs_hold_timer #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_q;

    assign expire = run && (cnt_q == CW'(HOLD - 1));

    // Count while running, clear when idle or at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hs_master.sv
// Sending side: takes a start when idle and both wires are low, drives request,
// removes it on timeout or on acknowledge per the latched discipline, pulses done.
// Assumes: ack_i is already in this clock domain.
module hs_master #(
    parameter int DATA_W   = 8,
    parameter int MST_HOLD = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              start_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic              done_o,
    output logic [DATA_W-1:0] tx_data_o,
    output hs_pkg::hs_mode_e  mode_o
);
    import hs_pkg::*;

    typedef enum logic [1:0] {M_IDLE, M_HOLD, M_DRAIN} mst_state_e;

    mst_state_e st_q;
    logic       tmr_exp;
    logic       tmr_run;

    assign tmr_run = (st_q == M_HOLD) && (mode_o == HS_UNLINKED);

    hs_hold_timer #(.HOLD(MST_HOLD)) u_req_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .expire (tmr_exp)
    );

    // Sender state machine, request wire and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= M_IDLE;
            req_o     <= 1'b0;
            done_o    <= 1'b0;
            tx_data_o <= '0;
            mode_o    <= HS_UNLINKED;
        end else begin
            done_o <= 1'b0;
            case (st_q)
                M_IDLE: begin
                    if (start_i && !req_o && !ack_i) begin
                        req_o     <= 1'b1;
                        tx_data_o <= wdata_i;
                        mode_o    <= hs_decode(mode_sel);
                        st_q      <= M_HOLD;
                    end
                end
                M_HOLD: begin
                    if (mode_o == HS_UNLINKED) begin
                        if (tmr_exp) begin
                            req_o  <= 1'b0;
                            done_o <= 1'b1;
                            st_q   <= M_IDLE;
                        end
                    end else if (ack_i) begin
                        req_o <= 1'b0;
                        if (mode_o == HS_HALF) begin
                            done_o <= 1'b1;
                            st_q   <= M_IDLE;
                        end else begin
                            st_q <= M_DRAIN;
                        end
                    end
                end
                M_DRAIN: begin
                    if (!ack_i) begin
                        done_o <= 1'b1;
                        st_q   <= M_IDLE;
                    end
                end
                default: st_q <= M_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hs_slave.sv
// Receiving side: captures the word on a request rise, raises acknowledge when
// ready, removes it on timeout or after request falls per the discipline.
// Assumes: req_i is already in this clock domain; mode_i is stable per transfer.
module hs_slave #(
    parameter int DATA_W   = 8,
    parameter int SLV_HOLD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hs_pkg::hs_mode_e  mode_i,
    input  logic              req_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              ready_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rx_data_o
);
    import hs_pkg::*;

    typedef enum logic [1:0] {S_IDLE, S_PEND, S_ACK} slv_state_e;

    slv_state_e st_q;
    logic       req_d;
    logic       req_rise;
    logic       tmr_exp;
    logic       tmr_run;

    assign req_rise = req_i && !req_d;
    assign tmr_run  = (st_q == S_ACK) && (mode_i != HS_FULL);

    hs_hold_timer #(.HOLD(SLV_HOLD)) u_ack_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .expire (tmr_exp)
    );

    // Edge detector and word capture on request rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d     <= 1'b0;
            rx_data_o <= '0;
        end else begin
            req_d <= req_i;
            if (req_rise) begin
                rx_data_o <= tx_data_i;
            end
        end
    end

    // Receiver state machine and acknowledge wire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            ack_o <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (req_rise) begin
                        if (ready_i) begin
                            ack_o <= 1'b1;
                            st_q  <= S_ACK;
                        end else begin
                            st_q <= S_PEND;
                        end
                    end
                end
                S_PEND: begin
                    if (ready_i) begin
                        ack_o <= 1'b1;
                        st_q  <= S_ACK;
                    end
                end
                S_ACK: begin
                    if (mode_i == HS_FULL) begin
                        if (!req_i) begin
                            ack_o <= 1'b0;
                            st_q  <= S_IDLE;
                        end
                    end else if (tmr_exp) begin
                        ack_o <= 1'b0;
                        st_q  <= S_IDLE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hs_link_ctrl.sv
// Top level: joins the sending and receiving state machines over the two wires.
// Assumes: single clock; the receiver follows the discipline latched by the sender.
module hs_link_ctrl #(
    parameter int DATA_W   = 8,
    parameter int MST_HOLD = 3,
    parameter int SLV_HOLD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              start_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              slv_ready_i,
    output logic              req_o,
    output logic              ack_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_data_o
);
    import hs_pkg::*;

    hs_mode_e          xfer_mode;
    logic [DATA_W-1:0] tx_word;

    hs_master #(.DATA_W(DATA_W), .MST_HOLD(MST_HOLD)) u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .start_i   (start_i),
        .wdata_i   (wdata_i),
        .ack_i     (ack_o),
        .req_o     (req_o),
        .done_o    (done_o),
        .tx_data_o (tx_word),
        .mode_o    (xfer_mode)
    );

    hs_slave #(.DATA_W(DATA_W), .SLV_HOLD(SLV_HOLD)) u_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (xfer_mode),
        .req_i     (req_o),
        .tx_data_i (tx_word),
        .ready_i   (slv_ready_i),
        .ack_o     (ack_o),
        .rx_data_o (rx_data_o)
    );
endmodule

// File: rtl/hs_link_chk.sv
// Protocol checker for hs_link_ctrl, attached by bind.
// Assumes: sampled on the same clock and reset as the controller.
module hs_link_chk (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic             ack,
    input logic             done,
    input hs_pkg::hs_mode_e mode
);
    import hs_pkg::*;

    // R2: a request only rises when acknowledge was low the cycle before.
    assert_req_rise_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> !$past(ack));

    // R6: in linked modes request holds until acknowledge is seen.
    assert_req_waits_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && mode != HS_UNLINKED) |=> req);

    // R7: fully linked acknowledge holds while request is high.
    assert_ack_waits_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == HS_FULL && ack && req) |=> ack);

    // R10: done is a single-cycle pulse.
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done never coincides with an active request.
    assert_done_req_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req);
endmodule

bind hs_link_ctrl hs_link_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_o),
    .ack   (ack_o),
    .done  (done_o),
    .mode  (xfer_mode)
);

// File: tb/test_hs_link_ctrl.sv
// Self-checking bench: table of transfers plus directed reset checks.
module test_hs_link_ctrl;
    localparam int DW  = 8;
    localparam int MH  = 3;
    localparam int SH  = 2;
    localparam int NV  = 10;
    localparam int WIN = 30;

    // Vector table: mode, ready lag, word, cycle of a stray start (-1 none), mode during stray start.
    localparam logic [1:0]    V_MODE [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd2, 2'd1, 2'd0};
    localparam int            V_LAG  [NV] = '{0, 2, 0, 3, 0, 4, 1, 5, 0, 6};
    localparam logic [DW-1:0] V_DATA [NV] = '{8'hA5, 8'h3C, 8'h81, 8'h7E, 8'h19, 8'hF0, 8'h42, 8'hC3, 8'h66, 8'h0F};
    localparam int            V_RS   [NV] = '{-1, -1, -1, -1, -1, -1, -1, 2, 2, 1};
    localparam logic [1:0]    V_ALT  [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2, 2'd1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_sel = 2'd0;
    logic          start_i = 1'b0;
    logic [DW-1:0] wdata_i = '0;
    logic          slv_ready_i = 1'b0;
    logic          req_o, ack_o, done_o;
    logic [DW-1:0] rx_data_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hs_link_ctrl #(.DATA_W(DW), .MST_HOLD(MH), .SLV_HOLD(SH)) i_hs_link_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_sel    (mode_sel),
        .start_i     (start_i),
        .wdata_i     (wdata_i),
        .slv_ready_i (slv_ready_i),
        .req_o       (req_o),
        .ack_o       (ack_o),
        .done_o      (done_o),
        .rx_data_o   (rx_data_o)
    );

    // Record one check and report a mismatch.
    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one transfer and check its timing at the wires.
    task automatic run_xfer(input logic [1:0] md, input int lag, input logic [DW-1:0] d,
                            input int rs_at, input logic [1:0] alt);
        int done_at = -1, done_cnt = 0, ack_at = -1, req_hi = 0, ack_hi = 0;
        int exp_done, exp_req, exp_ack;
        logic [DW-1:0] rx_seen = '0;
        if (md == 2'd0) begin
            exp_done = MH; exp_req = MH; exp_ack = SH;
        end else if (md == 2'd1) begin
            exp_done = 2 + lag; exp_req = 2 + lag; exp_ack = SH;
        end else begin
            exp_done = 4 + lag; exp_req = 2 + lag; exp_ack = 2;
        end
        @(negedge clk);
        mode_sel = md; wdata_i = d; start_i = 1'b1; slv_ready_i = (lag == 0);
        @(posedge clk);
        for (int n = 0; n < WIN; n++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (req_o) req_hi++;
            if (ack_o) begin
                ack_hi++;
                if (ack_at < 0) ack_at = n;
            end
            if (done_o) begin
                done_cnt++;
                if (done_at < 0) done_at = n;
            end
            if (n == 1) rx_seen = rx_data_o;
            slv_ready_i = (n >= lag);
            if (n == rs_at) begin
                start_i = 1'b1; wdata_i = ~d; mode_sel = alt;
            end
            @(posedge clk);
        end
        @(negedge clk);
        slv_ready_i = 1'b0; start_i = 1'b0;
        // R4 R6 R7: done timing per discipline; R3: mode latched at start
        check(md == 2'd0 ? "R4 done cycle" : (md == 2'd1 ? "R6 done cycle" : "R7 done cycle"),
              done_at, exp_done);
        // R10: exactly one done pulse; R2: stray start ignored
        check("R10 done count", done_cnt, 1);
        check(md == 2'd0 ? "R4 req high cycles" : "R2 req high cycles", req_hi, exp_req);
        check(md == 2'd2 || md == 2'd3 ? "R7 ack high cycles" : "R5 ack high cycles",
              ack_hi, exp_ack);
        check("R8 ack rise cycle", ack_at, 1 + lag);
        check("R9 captured word", int'(rx_seen), int'(d));
        check("R9 word after stray start", int'(rx_data_o), int'(d));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Main sequence: reset, table walk, reset during a transfer.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        check("R1 req reset", int'(req_o), 0);
        check("R1 ack reset", int'(ack_o), 0);
        check("R1 done reset", int'(done_o), 0);
        check("R1 rx reset", int'(rx_data_o), 0);
        rst_n = 1'b1;
        // R3 table includes codes 00, 01, 10, 11 and mid-transfer mode changes
        for (int v = 0; v < NV; v++) begin
            run_xfer(V_MODE[v], V_LAG[v], V_DATA[v], V_RS[v], V_ALT[v]);
        end
        // R1: reset in the middle of a fully linked transfer
        @(negedge clk);
        mode_sel = 2'd2; wdata_i = 8'h99; start_i = 1'b1; slv_ready_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 req after reset", int'(req_o), 0);
        check("R1 ack after reset", int'(ack_o), 0);
        check("R1 rx after reset", int'(rx_data_o), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule